// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block generates one or two pulse-width modulated outputs. Each output is produced by a channel with its own configuration words. Each channel divides the input clock by a programmable prescale factor. The resulting ticks drive a period counter, and the output stays high while that count is below the programmed duty value. A separate full-duty flag holds the output high for the whole period without any arithmetic on the duty field.

Software programs the channels through a small synchronous write port. The read data is decoded combinationally from the address. A per-channel enable input starts and stops each channel. When the enable drops, a per-channel stop-mode bit selects between two behaviours: cut the output off at the next clock, or let the running period finish first. Values written while a channel runs take effect only at the next period boundary.

Top module: `pwm_prescaled`

## Requirements
- R1: Channel c decodes at byte offset c*0x10. Offset +0x0 is the control word: prescale in bits 5:0 and stop-mode in bit 6. Offset +0x4 is the duty word: duty count in bits 9:0 and full-duty flag in bit 10. Offset +0x8 is the period word: PV in bits 9:0. Reads return the last written value with all other bits zero, and offset +0xC reads zero.
- R2: After the clock edge that samples the enable high, the output repeats with a period of (prescale+1)*(PV+1) input clocks, starting at count zero.
- R3: In each period the output is high for the first (prescale+1)*min(duty,PV+1) input clocks and low for the rest.
- R4: A duty count of zero keeps the output low for the entire period.
- R5: With the full-duty flag set, the output is high for the whole period whatever the duty count holds.
- R6: With stop-mode set and the enable low at a clock edge, the output is low after that edge.
- R7: With stop-mode clear, a dropped enable lets the current period finish unchanged, after which the output stays low.
- R8: Prescale, duty and period values written while a channel runs take effect only from the next period boundary.
- R9: Reset clears all configuration words to zero and drives the outputs low.
- R10: When two channels are built, the second channel at offset 0x10 runs independently of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (5) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr |
| ch_en | input | NUM_CH (2) | Per-channel run enable |
| pwm_out | output | NUM_CH (2) | Per-channel modulated output |

## Verification
The bench targets several corner cases.

- A duty count above PV+1 must saturate to a fully high period. A design that wrapped or truncated the comparison would drop pulses.
- A duty equal to PV+1, and a one-clock period, both expose off-by-one errors in the period wrap.
- A duty write in the middle of a period must not alter the remaining pulse. A design that loaded new values immediately would lose or stretch the pulse.
- Both stop modes are exercised: an abrupt stop must go low at the next clock, and a graceful stop must still emit the rest of the pulse. A design that mixed the two modes up would fail one of these tests.

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 6,
  parameter int PER_W  = 10,
  parameter int DW     = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int STOP_BIT = PRE_W;
  localparam int FULL_BIT = PER_W;

  logic [DW-1:0] ch_rd [NUM_CH];
  wire unused_bus = ^{bus_addr[1:0], bus_wdata[DW-1:FULL_BIT+1]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PRE_W-1:0] cfg_pre, act_pre, pre_cnt;
    logic [PER_W-1:0] cfg_dc, act_dc, cfg_pv, act_pv, per_cnt;
    logic             cfg_stop, cfg_full, act_full, run;

    wire hit  = (bus_addr[AW-1] == 1'(c));
    wire tick = run && (pre_cnt == act_pre);
    wire wrap = tick && (per_cnt == act_pv);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_pre  <= '0;
        cfg_stop <= 1'b0;
        cfg_dc   <= '0;
        cfg_full <= 1'b0;
        cfg_pv   <= '0;
      end else if (bus_wr && hit) begin
        case (bus_addr[3:2])
          2'd0: begin
            cfg_pre  <= bus_wdata[PRE_W-1:0];
            cfg_stop <= bus_wdata[STOP_BIT];
          end
          2'd1: begin
            cfg_dc   <= bus_wdata[PER_W-1:0];
            cfg_full <= bus_wdata[FULL_BIT];
          end
          2'd2: cfg_pv <= bus_wdata[PER_W-1:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run      <= 1'b0;
        pre_cnt  <= '0;
        per_cnt  <= '0;
        act_pre  <= '0;
        act_dc   <= '0;
        act_pv   <= '0;
        act_full <= 1'b0;
      end else if (!run || wrap) begin
        pre_cnt <= '0;
        per_cnt <= '0;
        run     <= ch_en[c];
        if (ch_en[c]) begin
          act_pre  <= cfg_pre;
          act_dc   <= cfg_dc;
          act_pv   <= cfg_pv;
          act_full <= cfg_full;
        end
      end else if (!ch_en[c] && cfg_stop) begin
        run <= 1'b0;
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) per_cnt <= per_cnt + 1'b1;
      end
    end

    assign pwm_out[c] = run && (act_full || (per_cnt < act_dc));

    always_comb begin
      ch_rd[c] = '0;
      if (hit) begin
        case (bus_addr[3:2])
          2'd0: ch_rd[c] = DW'({cfg_stop, cfg_pre});
          2'd1: ch_rd[c] = DW'({cfg_full, cfg_dc});
          2'd2: ch_rd[c] = DW'(cfg_pv);
          default: ch_rd[c] = '0;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rd[i];
  end
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 6,
  parameter int PER_W  = 10,
  parameter int DW     = 32,
  parameter int AW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] pwm_out
);
  logic stop0;
  always_ff @(posedge clk) begin
    if (!rst_n) stop0 <= 1'b0;
    else if (bus_wr && bus_addr == '0) stop0 <= bus_wdata[PRE_W];
  end

  // R1
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> (bus_addr != '0 || bus_rdata == DW'($past(bus_wdata[PRE_W:0]))));

  // R1
  duty_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd1) |-> (bus_rdata[DW-1:PER_W+1] == '0));

  // R1
  period_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd2) |-> (bus_rdata[DW-1:PER_W] == '0));

  // R6
  abrupt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en[0] && stop0) |=> !pwm_out[0]);

  // R7
  idle_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en[0] && !pwm_out[0]) |=> !pwm_out[0]);
endmodule

bind pwm_prescaled pwm_prescaled_chk #(
  .NUM_CH(NUM_CH), .PRE_W(PRE_W), .PER_W(PER_W), .DW(DW), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en), .pwm_out(pwm_out)
);

// File: tb/pwm_prescaled_tb_top.sv
module pwm_prescaled_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_prescaled dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en), .pwm_out(pwm_out)
  );

  // columns: prescale, PV, duty, full flag, expected high clocks per period
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0, 9, 3, 0, 3},
    '{2, 4, 2, 0, 6},
    '{1, 7, 0, 0, 0},
    '{3, 3, 9, 0, 16},
    '{1, 5, 2, 1, 12},
    '{0, 0, 1, 0, 1},
    '{5, 2, 3, 0, 18}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v, hi, p, first, last;
    string tag;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out", int'(pwm_out), 0);
    rst_n = 1'b1;
    rd(5'h00, v); check("R9 ctrl", v, 0);
    rd(5'h04, v); check("R9 duty", v, 0);
    rd(5'h08, v); check("R9 period", v, 0);

    // R1 readback masks
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v); check("R1 ctrl", v, 32'h7F);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); check("R1 duty", v, 32'h7FF);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); check("R1 period", v, 32'h3FF);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); check("R1 unmapped", v, 0);

    for (int k = 0; k < NV; k++) begin
      tag = (VEC[k][2] == 0) ? "R4" : (VEC[k][3] != 0) ? "R5" : "R3";
      wr(5'h00, 32'h40 | VEC[k][0]);
      wr(5'h04, (VEC[k][3] << 10) | VEC[k][2]);
      wr(5'h08, VEC[k][1]);
      p = (VEC[k][0] + 1) * (VEC[k][1] + 1);
      @(negedge clk); ch_en[0] = 1'b1;
      hi = 0;
      for (int n = 0; n < p; n++) begin @(negedge clk); hi += int'(pwm_out[0]); end
      check(tag, hi, VEC[k][4]);
      hi = 0;
      for (int n = 0; n < p; n++) begin
        @(negedge clk);
        hi += int'(pwm_out[0]);
        if (n == 0) first = int'(pwm_out[0]);
        if (n == p - 1) last = int'(pwm_out[0]);
      end
      check("R2 repeat", hi, VEC[k][4]);
      if (VEC[k][4] > 0) check("R2 start high", first, 1);
      if (VEC[k][4] < p) check("R2 end low", last, 0);
      @(negedge clk); ch_en[0] = 1'b0;
      @(negedge clk); check("R6 abrupt", int'(pwm_out[0]), 0);
    end

    // R7 graceful stop
    wr(5'h00, 0); wr(5'h04, 5); wr(5'h08, 9);
    @(negedge clk); ch_en[0] = 1'b1;
    hi = 0;
    for (int n = 0; n < 3; n++) begin @(negedge clk); hi += int'(pwm_out[0]); end
    ch_en[0] = 1'b0;
    check("R7 before drop", hi, 3);
    hi = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); hi += int'(pwm_out[0]); end
    check("R7 tail", hi, 2);
    check("R7 idle", int'(pwm_out[0]), 0);

    // R8 boundary latch
    wr(5'h04, 2);
    @(negedge clk); ch_en[0] = 1'b1;
    hi = 0;
    for (int n = 0; n < 4; n++) begin @(negedge clk); hi += int'(pwm_out[0]); end
    check("R8 first part", hi, 2);
    bus_addr = 5'h04; bus_wdata = 8; bus_wr = 1'b1;
    hi = 0;
    for (int n = 4; n < 10; n++) begin
      @(negedge clk); bus_wr = 1'b0; hi += int'(pwm_out[0]);
    end
    check("R8 rest unchanged", hi, 0);
    hi = 0;
    for (int n = 0; n < 10; n++) begin @(negedge clk); hi += int'(pwm_out[0]); end
    check("R8 next period", hi, 8);
    rd(5'h04, v); check("R8 readback", v, 8);
    ch_en[0] = 1'b0;
    repeat (12) @(negedge clk);

    // R10 second channel
    wr(5'h10, 32'h41); wr(5'h14, 3); wr(5'h18, 3);
    rd(5'h10, v); check("R10 ctrl1", v, 32'h41);
    rd(5'h00, v); check("R10 ctrl0 kept", v, 0);
    @(negedge clk); ch_en[1] = 1'b1;
    hi = 0; first = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); hi += int'(pwm_out[1]); first += int'(pwm_out[0]);
    end
    check("R10 ch1 high", hi, 6);
    check("R10 ch0 quiet", first, 0);
    ch_en[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 ch1 abrupt", int'(pwm_out[1]), 0);

    finish_run();
  end
endmodule